// File: doc/BRIEF.md
# Low-Latency Kernel Integrator and State Discriminator

This block reduces a stream of raw converter samples to one binary state decision per readout channel, with only two clock cycles from the final sample to the answer. Each clock brings four signed samples, which are added into one sample per clock. Every channel multiplies that sample by a complex coefficient taken from its own writable kernel memory. The kernel already carries the demodulation and the channel-selecting filter, so no separate mixer or filter stage comes before it. The real and imaginary products are summed over a record of programmable length.

A start pulse opens a record. It clears the sums and restarts the kernel address at zero. When the last product has been added, each channel compares the real sum with its own signed threshold. A shared one-cycle strobe then presents the decision bits and the complex totals. Several channels run side by side on the same input, so one input line can carry several frequency-multiplexed measurements. Kernel contents can be loaded only while no record is in progress.

Top module: `kdec_top`

## Requirements
- R1: Each clock, the four lanes of `adc_in` are added as signed 12-bit two's-complement values into one sample. Lane k sits at bits [12k+11:12k].
- R2: For channel c, `res_re` equals the sum over j of s_j·KRE_c[j] and `res_im` equals the sum over j of s_j·KIM_c[j]. Here s_j is the j-th summed sample of the record, and kernel address j is the sample index counted from 0.
- R3: The record length is captured from `rec_len` on the start edge. A value of 0 counts as 1, and values above KDEPTH count as KDEPTH. The samples are taken on the L edges that follow the start edge.
- R4: `dec_bit[c]` is 1 exactly when the signed real total is strictly greater than the signed threshold `thresh[c]`. Otherwise it is 0.
- R5: `dec_valid` is high for exactly one cycle, on the second edge after the edge that captures the final sample. The bits and totals change only on that edge and hold until the next result.
- R6: The totals are exact at the largest record length with full-scale samples and coefficients. They never wrap.
- R7: `busy` rises on the edge that accepts `rec_start` and falls on the edge that raises `dec_valid`. A `rec_start` pulse seen while `busy` is high is ignored. A new record may begin on the edge right after the strobe.
- R8: A kernel write (`kwr_en` with channel `kwr_ch`, address `kwr_addr`, coefficient parts `kwr_re`/`kwr_im`) takes effect only while `busy` is low. A write while busy leaves the memory unchanged.
- R9: After reset, `busy`, `dec_valid`, `dec_bit` and both totals are zero.
- R10: Every channel has its own kernel and threshold. All channels report on the same strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_start | input | 1 | Record start pulse |
| rec_len | input | LEN_W (7) | Requested record length in samples |
| adc_in | input | LANES·SAMP_W (48) | Four packed signed samples |
| thresh | input | NCH·ACC_W (74) | Signed threshold per channel |
| kwr_en | input | 1 | Kernel write strobe |
| kwr_ch | input | CH_W (1) | Kernel write channel select |
| kwr_addr | input | ADDR_W (6) | Kernel write address |
| kwr_re | input | COEF_W (16) | Real coefficient part |
| kwr_im | input | COEF_W (16) | Imaginary coefficient part |
| busy | output | 1 | Record in progress |
| dec_valid | output | 1 | One-cycle result strobe |
| dec_bit | output | NCH (2) | State decision per channel |
| res_re | output | NCH·ACC_W (74) | Signed real totals |
| res_im | output | NCH·ACC_W (74) | Signed imaginary totals |

## Verification
If the start pulse is accepted on edge E0, `busy` can be seen right after E0. Sample j must be present at edge E0+1+j. The strobe, bits and totals are due right after edge E0+L+2. The bench counts edges and files the expected result of each record under that edge number. It compares outputs at the falling edge of every cycle, so it requires the strobe in the due cycle and its absence in every other cycle. A late, early, doubled or spurious result therefore shows up as a mismatch in the cycle where it happens.

// File: rtl/kdec_pkg.sv
package kdec_pkg;

  // Accumulator width: product width plus growth for depth terms plus one guard bit.
  function automatic int acc_width(input int prod_w, input int depth);
    return prod_w + $clog2(depth) + 1;
  endfunction

  // Effective record length: at least one sample, at most the kernel depth.
  function automatic int clamp_len(input int req, input int depth);
    if (req < 1) return 1;
    if (req > depth) return depth;
    return req;
  endfunction

endpackage

// File: rtl/kdec_front.sv
module kdec_front #(
  parameter int LANES  = 4,
  parameter int SAMP_W = 12,
  parameter int KDEPTH = 64,
  parameter int LEN_W  = 7,
  parameter int ADDR_W = 6,
  parameter int SUM_W  = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rec_start,
  input  logic [LEN_W-1:0]          rec_len,
  input  logic [LANES*SAMP_W-1:0]   adc_in,
  output logic                      start_ok,
  output logic                      rd_en,
  output logic [ADDR_W-1:0]         rd_addr,
  output logic signed [SUM_W-1:0]   s_sum,
  output logic                      s_vld,
  output logic                      s_last,
  output logic                      busy
);

  function automatic logic signed [SUM_W-1:0] lane_sum(input logic [LANES*SAMP_W-1:0] v);
    logic signed [SUM_W-1:0] t;
    t = '0;
    for (int k = 0; k < LANES; k++)
      t = t + {{(SUM_W-SAMP_W){v[k*SAMP_W+SAMP_W-1]}}, v[k*SAMP_W +: SAMP_W]};
    return t;
  endfunction

  logic             running;
  logic             tail;
  logic             at_end;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;

  assign at_end   = (cnt == len_q - LEN_W'(1));
  assign start_ok = rec_start && !busy;
  assign rd_en    = running;
  assign rd_addr  = cnt[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      tail    <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
      s_sum   <= '0;
      s_vld   <= 1'b0;
      s_last  <= 1'b0;
      busy    <= 1'b0;
    end else begin
      s_vld  <= running;
      s_last <= running && at_end;
      tail   <= s_vld && s_last;
      if (running) begin
        s_sum <= lane_sum(adc_in);
        cnt   <= cnt + LEN_W'(1);
        if (at_end) running <= 1'b0;
      end
      if (start_ok) begin
        running <= 1'b1;
        cnt     <= '0;
        len_q   <= LEN_W'(kdec_pkg::clamp_len(int'(rec_len), KDEPTH));
        busy    <= 1'b1;
      end else if (tail) begin
        busy <= 1'b0;
      end
    end
  end

  // R3
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < len_q) && (len_q != '0) && (len_q <= LEN_W'(KDEPTH)));

  // R7
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_start && busy && running) |=> (cnt == $past(cnt) + LEN_W'(1)));

endmodule

// File: rtl/kdec_kram.sv
module kdec_kram #(
  parameter int COEF_W = 16,
  parameter int KDEPTH = 64,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic signed [COEF_W-1:0]  wre,
  input  logic signed [COEF_W-1:0]  wim,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         raddr,
  output logic signed [COEF_W-1:0]  c_re,
  output logic signed [COEF_W-1:0]  c_im
);

  logic signed [COEF_W-1:0] mre [KDEPTH];
  logic signed [COEF_W-1:0] mim [KDEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mre[waddr] <= wre;
      mim[waddr] <= wim;
    end
    if (rd_en) begin
      c_re <= mre[raddr];
      c_im <= mim[raddr];
    end
  end

endmodule

// File: rtl/kdec_chan.sv
module kdec_chan #(
  parameter int SUM_W  = 14,
  parameter int COEF_W = 16,
  parameter int KDEPTH = 64,
  parameter int ADDR_W = 6,
  parameter int ACC_W  = 37,
  parameter int CH_W   = 1,
  parameter int CH_IDX = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_ok,
  input  logic                      busy,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic signed [SUM_W-1:0]   s_sum,
  input  logic                      s_vld,
  input  logic                      s_last,
  input  logic                      kwr_en,
  input  logic [CH_W-1:0]           kwr_ch,
  input  logic [ADDR_W-1:0]         kwr_addr,
  input  logic signed [COEF_W-1:0]  kwr_re,
  input  logic signed [COEF_W-1:0]  kwr_im,
  input  logic signed [ACC_W-1:0]   thr,
  output logic                      dv,
  output logic                      dbit,
  output logic signed [ACC_W-1:0]   res_re,
  output logic signed [ACC_W-1:0]   res_im
);

  localparam int PROD_W = SUM_W + COEF_W;

  function automatic logic signed [PROD_W-1:0] smul(input logic signed [SUM_W-1:0] a,
                                                    input logic signed [COEF_W-1:0] b);
    logic signed [PROD_W-1:0] ax;
    logic signed [PROD_W-1:0] bx;
    ax = {{COEF_W{a[SUM_W-1]}}, a};
    bx = {{SUM_W{b[COEF_W-1]}}, b};
    return ax * bx;
  endfunction

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [PROD_W-1:0] p);
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  logic                      wr_ok;
  logic signed [COEF_W-1:0]  c_re;
  logic signed [COEF_W-1:0]  c_im;
  logic signed [PROD_W-1:0]  p_re;
  logic signed [PROD_W-1:0]  p_im;
  logic                      p_vld;
  logic                      p_last;
  logic signed [ACC_W-1:0]   acc_re;
  logic signed [ACC_W-1:0]   acc_im;
  logic signed [ACC_W-1:0]   nxt_re;
  logic signed [ACC_W-1:0]   nxt_im;

  assign wr_ok  = kwr_en && !busy && (kwr_ch == CH_W'(CH_IDX));
  assign nxt_re = acc_re + widen(p_re);
  assign nxt_im = acc_im + widen(p_im);

  kdec_kram #(.COEF_W(COEF_W), .KDEPTH(KDEPTH), .ADDR_W(ADDR_W)) u_kram (
    .clk   (clk),
    .wr_en (wr_ok),
    .waddr (kwr_addr),
    .wre   (kwr_re),
    .wim   (kwr_im),
    .rd_en (rd_en),
    .raddr (rd_addr),
    .c_re  (c_re),
    .c_im  (c_im)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_re   <= '0;
      p_im   <= '0;
      p_vld  <= 1'b0;
      p_last <= 1'b0;
      acc_re <= '0;
      acc_im <= '0;
      dv     <= 1'b0;
      dbit   <= 1'b0;
      res_re <= '0;
      res_im <= '0;
    end else begin
      p_vld  <= s_vld;
      p_last <= s_vld && s_last;
      if (s_vld) begin
        p_re <= smul(s_sum, c_re);
        p_im <= smul(s_sum, c_im);
      end
      dv <= p_last;
      if (start_ok) begin
        acc_re <= '0;
        acc_im <= '0;
      end else if (p_vld) begin
        acc_re <= nxt_re;
        acc_im <= nxt_im;
      end
      if (p_last) begin
        res_re <= nxt_re;
        res_im <= nxt_im;
        dbit   <= (nxt_re > thr);
      end
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re[ACC_W-1] == acc_re[ACC_W-2]) && (acc_im[ACC_W-1] == acc_im[ACC_W-2]));

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dv |=> !dv);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dv |-> $stable(res_re) && $stable(res_im) && $stable(dbit));

endmodule

// File: rtl/kdec_top.sv
module kdec_top #(
  parameter int LANES  = 4,
  parameter int SAMP_W = 12,
  parameter int COEF_W = 16,
  parameter int KDEPTH = 64,
  parameter int NCH    = 2,
  localparam int SUM_W  = SAMP_W + $clog2(LANES),
  localparam int PROD_W = SUM_W + COEF_W,
  localparam int ACC_W  = kdec_pkg::acc_width(PROD_W, KDEPTH),
  localparam int LEN_W  = $clog2(KDEPTH + 1),
  localparam int ADDR_W = $clog2(KDEPTH),
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rec_start,
  input  logic [LEN_W-1:0]          rec_len,
  input  logic [LANES*SAMP_W-1:0]   adc_in,
  input  logic [NCH*ACC_W-1:0]      thresh,
  input  logic                      kwr_en,
  input  logic [CH_W-1:0]           kwr_ch,
  input  logic [ADDR_W-1:0]         kwr_addr,
  input  logic [COEF_W-1:0]         kwr_re,
  input  logic [COEF_W-1:0]         kwr_im,
  output logic                      busy,
  output logic                      dec_valid,
  output logic [NCH-1:0]            dec_bit,
  output logic [NCH*ACC_W-1:0]      res_re,
  output logic [NCH*ACC_W-1:0]      res_im
);

  logic                     start_ok;
  logic                     rd_en;
  logic [ADDR_W-1:0]        rd_addr;
  logic signed [SUM_W-1:0]  s_sum;
  logic                     s_vld;
  logic                     s_last;
  logic [NCH-1:0]           dv_all;

  kdec_front #(
    .LANES(LANES), .SAMP_W(SAMP_W), .KDEPTH(KDEPTH),
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .SUM_W(SUM_W)
  ) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_start (rec_start),
    .rec_len   (rec_len),
    .adc_in    (adc_in),
    .start_ok  (start_ok),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .s_sum     (s_sum),
    .s_vld     (s_vld),
    .s_last    (s_last),
    .busy      (busy)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    kdec_chan #(
      .SUM_W(SUM_W), .COEF_W(COEF_W), .KDEPTH(KDEPTH), .ADDR_W(ADDR_W),
      .ACC_W(ACC_W), .CH_W(CH_W), .CH_IDX(g)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_ok (start_ok),
      .busy     (busy),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .s_sum    (s_sum),
      .s_vld    (s_vld),
      .s_last   (s_last),
      .kwr_en   (kwr_en),
      .kwr_ch   (kwr_ch),
      .kwr_addr (kwr_addr),
      .kwr_re   (kwr_re),
      .kwr_im   (kwr_im),
      .thr      (thresh[g*ACC_W +: ACC_W]),
      .dv       (dv_all[g]),
      .dbit     (dec_bit[g]),
      .res_re   (res_re[g*ACC_W +: ACC_W]),
      .res_im   (res_im[g*ACC_W +: ACC_W])
    );
  end

  assign dec_valid = dv_all[0];

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> dec_valid);

  // R10
  strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_all == '0) || (dv_all == '1));

endmodule

// File: tb/kdec_top_bench.sv
`timescale 1ns/1ps
module kdec_top_bench;

  localparam int NCH = 2;
  localparam int KD  = 64;
  localparam int AW  = 37;   // 14-bit sum + 16-bit coef + 6 growth + 1 guard

  typedef struct {
    longint due;
    longint re [NCH];
    longint im [NCH];
    bit     d  [NCH];
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rec_start = 1'b0;
  logic [6:0]       rec_len = '0;
  logic [47:0]      adc_in = '0;
  logic [NCH*AW-1:0] thresh = '0;
  logic             kwr_en = 1'b0;
  logic [0:0]       kwr_ch = '0;
  logic [5:0]       kwr_addr = '0;
  logic [15:0]      kwr_re = '0;
  logic [15:0]      kwr_im = '0;
  logic             busy;
  logic             dec_valid;
  logic [NCH-1:0]   dec_bit;
  logic [NCH*AW-1:0] res_re;
  logic [NCH*AW-1:0] res_im;

  kdec_top u_kdec_top (
    .clk(clk), .rst_n(rst_n), .rec_start(rec_start), .rec_len(rec_len),
    .adc_in(adc_in), .thresh(thresh), .kwr_en(kwr_en), .kwr_ch(kwr_ch),
    .kwr_addr(kwr_addr), .kwr_re(kwr_re), .kwr_im(kwr_im), .busy(busy),
    .dec_valid(dec_valid), .dec_bit(dec_bit), .res_re(res_re), .res_im(res_im)
  );

  always #4 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int     n_chk = 0;
  int     n_fail = 0;
  bit     mon_on = 1'b0;
  string  cur_tag = "R9";
  longint last_due = 0;
  int     kre [NCH][KD];
  int     kim [NCH][KD];
  longint thr_m [NCH];
  int     lane_v [KD][4];
  exp_t   q [$];
  exp_t   cur;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Cycle-by-cycle comparison against the queued expectations.
  always @(negedge clk) begin
    if (mon_on) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        cur = q.pop_front();
        chk(dec_valid === 1'b1, {cur_tag, " R5 strobe"}, longint'(dec_valid), 1);
        for (int c = 0; c < NCH; c++) begin
          chk(longint'($signed(res_re[c*AW +: AW])) == cur.re[c], {cur_tag, " R1 R2 real"},
              longint'($signed(res_re[c*AW +: AW])), cur.re[c]);
          chk(longint'($signed(res_im[c*AW +: AW])) == cur.im[c], {cur_tag, " R2 imag"},
              longint'($signed(res_im[c*AW +: AW])), cur.im[c]);
          chk(dec_bit[c] === cur.d[c], {cur_tag, " R4 R10 decision"},
              longint'(dec_bit[c]), longint'(cur.d[c]));
        end
      end else begin
        chk(dec_valid === 1'b0, {cur_tag, " R5 no strobe"}, longint'(dec_valid), 0);
      end
    end
  end

  function automatic logic [47:0] pack(input int j);
    logic [47:0] v;
    for (int k = 0; k < 4; k++) v[k*12 +: 12] = 12'(lane_v[j][k]);
    return v;
  endfunction

  task automatic fill_random();
    for (int j = 0; j < KD; j++)
      for (int k = 0; k < 4; k++) lane_v[j][k] = int'($urandom_range(4095)) - 2048;
  endtask

  task automatic set_thr(input int c, input longint v);
    thr_m[c] = v;
    thresh[c*AW +: AW] = AW'(v);
  endtask

  task automatic kw(input int c, input int a, input int vr, input int vi);
    @(negedge clk);
    kwr_en = 1'b1; kwr_ch = 1'(c); kwr_addr = 6'(a); kwr_re = 16'(vr); kwr_im = 16'(vi);
    @(negedge clk);
    kwr_en = 1'b0;
    kre[c][a] = vr;
    kim[c][a] = vi;
  endtask

  function automatic longint ref_re(input int c, input int el);
    longint a = 0;
    for (int j = 0; j < el; j++)
      a += longint'(lane_v[j][0] + lane_v[j][1] + lane_v[j][2] + lane_v[j][3]) * kre[c][j];
    return a;
  endfunction

  task automatic launch(input int req, input bit now, input bit inj_s, input bit inj_k);
    int     el;
    exp_t   e;
    longint sj;
    el = (req < 1) ? 1 : (req > KD) ? KD : req;
    for (int c = 0; c < NCH; c++) begin e.re[c] = 0; e.im[c] = 0; end
    for (int j = 0; j < el; j++) begin
      sj = longint'(lane_v[j][0] + lane_v[j][1] + lane_v[j][2] + lane_v[j][3]);
      for (int c = 0; c < NCH; c++) begin
        e.re[c] += sj * kre[c][j];
        e.im[c] += sj * kim[c][j];
      end
    end
    for (int c = 0; c < NCH; c++) e.d[c] = (e.re[c] > thr_m[c]);
    if (!now) @(negedge clk);
    rec_start = 1'b1;
    rec_len = 7'(req);
    @(negedge clk);
    rec_start = 1'b0;
    chk(busy === 1'b1, {cur_tag, " R7 busy after start"}, longint'(busy), 1);
    e.due = cyc + el + 2;
    last_due = e.due;
    q.push_back(e);
    for (int j = 0; j < el; j++) begin
      adc_in = pack(j);
      rec_start = inj_s && (j == 2);
      if (inj_k && j == 3) begin
        kwr_en = 1'b1; kwr_ch = 1'b0; kwr_addr = 6'd0; kwr_re = 16'h1234; kwr_im = 16'h4321;
      end else begin
        kwr_en = 1'b0;
      end
      @(negedge clk);
    end
    adc_in = '0;
    rec_start = 1'b0;
    kwr_en = 1'b0;
  endtask

  task automatic wait_done();
    while (cyc < last_due) @(negedge clk);
    chk(busy === 1'b0, {cur_tag, " R7 idle at strobe"}, longint'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    longint r;
    void'($urandom(7));
    for (int c = 0; c < NCH; c++) thr_m[c] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(busy === 1'b0, "R9 busy", longint'(busy), 0);
    chk(dec_valid === 1'b0, "R9 strobe", longint'(dec_valid), 0);
    chk(dec_bit === '0, "R9 bits", longint'(dec_bit), 0);
    chk(res_re === '0 && res_im === '0, "R9 totals", 1, 0);
    mon_on = 1'b1;

    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < KD; a++)
        kw(c, a, int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768);

    cur_tag = "R1 R2";
    fill_random();
    launch(8, 0, 0, 0);
    wait_done();

    cur_tag = "R10";
    fill_random();
    set_thr(0, 64'sd1000000000);
    set_thr(1, -64'sd1000000000);
    launch(16, 0, 0, 0);
    wait_done();

    cur_tag = "R4";
    fill_random();
    r = ref_re(0, 5);
    set_thr(0, r);
    launch(5, 0, 0, 0);
    wait_done();
    set_thr(0, r - 1);
    launch(5, 0, 0, 0);
    wait_done();

    cur_tag = "R3";
    set_thr(0, 0);
    set_thr(1, 0);
    fill_random();
    launch(0, 0, 0, 0);
    wait_done();
    launch(100, 0, 0, 0);
    wait_done();
    launch(64, 0, 0, 0);
    wait_done();

    cur_tag = "R6";
    for (int a = 0; a < KD; a++) kw(0, a, -32768, 32767);
    for (int j = 0; j < KD; j++)
      for (int k = 0; k < 4; k++) lane_v[j][k] = -2048;
    launch(64, 0, 0, 0);
    wait_done();

    cur_tag = "R7";
    fill_random();
    launch(12, 0, 1, 0);
    wait_done();
    launch(6, 1, 0, 0);
    wait_done();

    cur_tag = "R8";
    launch(10, 0, 0, 1);
    wait_done();
    launch(10, 0, 0, 0);
    wait_done();

    repeat (6) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule